// File: doc/BRIEF.md
# Speculative Load Alias Monitor

This block lets a scheduler hoist a load above earlier stores whose addresses were unknown at schedule time. When a hoisted load issues, the block records its destination register tag and its address in a small fully associative table and starts to watch for stores. Every store that follows is compared against all recorded addresses. Any matching entry loses its armed state.

At the original position of the load, a check names the same register. If the entry is still armed, the check does nothing. Otherwise one of two things happens. The plain check asks the pipeline to reload the value from memory, and it re-arms the entry with its stored address. The branching check asks the front end to jump to recovery code, so that consumers that already ran on stale data can be redone. An aliased branching check also releases the entry. A register with no entry counts as aliased. This covers a tag that was never recorded and a tag that lost its slot when the table was full.

Requests arriving in the same cycle take effect in a fixed program order: the store first, then the check, then the new hoisted load. Reload and recovery requests are registered and appear one cycle after the check.

Top module: `spec_ld_monitor`

## Requirements
- R1: While rst_ni is low, and in the cycle after it rises, reload_o and recover_o are 0. After reset the table is empty.
- R2: A check on a register whose entry is armed produces neither reload_o nor recover_o. Both outputs are 0 in every cycle that does not follow a check.
- R3: A store disarms an entry when bits [ADDR_W-1:3] of the two addresses are equal. A store whose address differs in any of those bits leaves the entry armed.
- R4: A plain check (chk_branch_i = 0) on an aliased register sets reload_o to 1 for exactly the next cycle. recover_o stays 0.
- R5: A branching check (chk_branch_i = 1) on an aliased register sets recover_o to 1 for exactly the next cycle. reload_o stays 0. The entry is released, so a later check on that register is aliased.
- R6: A plain check that requests a reload re-arms the entry with its recorded address. A second check with no store in between is then a no-op.
- R7: A hoisted load to a register that already has an entry overwrites that entry's address and arms it. Stores to the old address no longer affect it.
- R8: A hoisted load with a new tag takes the lowest-numbered free entry. When all ENTRIES entries are in use, it evicts entries in round-robin order starting at entry 0. A check on an evicted register is aliased.
- R9: A check on a register that has no entry is treated as aliased.
- R10: Requests in the same cycle apply in the order store, then check, then hoisted load. A check sees the disarming done by a store in the same cycle. A hoisted load in the same cycle is armed, regardless of the same-cycle store.
- R11: A single store disarms every matching entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_valid_i | input | 1 | Hoisted load issues this cycle |
| adv_tag_i | input | TAG_W | Destination register of the hoisted load |
| adv_addr_i | input | ADDR_W | Address of the hoisted load |
| st_valid_i | input | 1 | Store issues this cycle |
| st_addr_i | input | ADDR_W | Store address |
| chk_valid_i | input | 1 | Check issues this cycle |
| chk_branch_i | input | 1 | 0 = reload variant, 1 = branching variant |
| chk_tag_i | input | TAG_W | Register named by the check |
| reload_o | output | 1 | Reload request, one cycle after an aliased plain check |
| recover_o | output | 1 | Recovery branch request, one cycle after an aliased branching check |

## Verification
Errors in the table's internal state show up at the ports only when a check is made. A wrongly cleared armed bit appears as a spurious reload or recovery one cycle after the next check on that register. A missed clear appears as a silent check where a request was due. A wrong victim choice or a wrong round-robin pointer shows up only when a later check lands on the wrong surviving register, which can be many cycles after the eviction. For this reason the stimulus checks registers both right after they are disturbed and long after they were evicted.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  typedef enum logic {
    CHK_RELOAD = 1'b0,
    CHK_BRANCH = 1'b1
  } chk_kind_e;

  localparam int unsigned GRAN_LSB = 3;  // 8-byte compare granule
endpackage

// File: rtl/spec_ld_slot.sv
module spec_ld_slot #(
  parameter int unsigned TAG_W  = 7,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LSB    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  input  logic [TAG_W-1:0]  adv_tag_i,
  input  logic              rearm_i,
  input  logic              free_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              used_o,
  output logic              armed_o,
  output logic              armed_post_o,
  output logic              chk_match_o,
  output logic              adv_match_o
);
  logic              used_q, armed_q;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic              st_hit;

  assign st_hit = st_valid_i & used_q & armed_q &
                  (addr_q[ADDR_W-1:LSB] == st_addr_i[ADDR_W-1:LSB]);
  assign armed_post_o = armed_q & ~st_hit;
  assign chk_match_o  = used_q & (tag_q == chk_tag_i);
  assign adv_match_o  = used_q & (tag_q == adv_tag_i);
  assign used_o       = used_q;
  assign armed_o      = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= 1'b0;
      armed_q <= 1'b0;
      tag_q   <= '0;
      addr_q  <= '0;
    end else if (wr_i) begin
      used_q  <= 1'b1;
      armed_q <= 1'b1;
      tag_q   <= adv_tag_i;
      addr_q  <= wr_addr_i;
    end else if (free_i) begin
      used_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_post_o | rearm_i;
    end
  end
endmodule

// File: rtl/spec_ld_victim.sv
module spec_ld_victim #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     used_i,
  input  logic             evict_i,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             full_o,
  output logic [IDX_W-1:0] victim_idx_o
);
  logic [IDX_W-1:0] rr_q;

  assign full_o       = &used_i;
  assign victim_idx_o = rr_q;

  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (evict_i) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/spec_ld_monitor.sv
module spec_ld_monitor #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 7,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_valid_i,
  input  logic [TAG_W-1:0]  adv_tag_i,
  input  logic [ADDR_W-1:0] adv_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              chk_valid_i,
  input  logic              chk_branch_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  output logic              reload_o,
  output logic              recover_o
);
  import spec_ld_pkg::*;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] used_vec, armed_vec, armed_post, chk_match, adv_match;
  logic [ENTRIES-1:0] rearm_vec, free_vec, wr_vec;
  logic [IDX_W-1:0]   match_idx, free_idx, victim_idx, alloc_idx;
  logic               adv_hit, table_full, aliased, evict;
  logic               reload_q, recover_q;
  chk_kind_e          kind;

  assign kind    = chk_kind_e'(chk_branch_i);
  assign adv_hit = |adv_match;
  // armed_post already reflects a same-cycle store (store precedes check)
  assign aliased = ~|(chk_match & armed_post);
  assign evict   = adv_valid_i & ~adv_hit & table_full;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (adv_match[i]) match_idx = IDX_W'(i);
    end
  end

  assign alloc_idx = adv_hit ? match_idx : (table_full ? victim_idx : free_idx);

  spec_ld_victim #(.N(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .used_i       (used_vec),
    .evict_i      (evict),
    .free_idx_o   (free_idx),
    .full_o       (table_full),
    .victim_idx_o (victim_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign rearm_vec[g] = chk_valid_i & (kind == CHK_RELOAD) & chk_match[g] & ~armed_post[g];
    assign free_vec[g]  = chk_valid_i & (kind == CHK_BRANCH) & chk_match[g] & ~armed_post[g];
    assign wr_vec[g]    = adv_valid_i & (alloc_idx == IDX_W'(g));

    spec_ld_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LSB(GRAN_LSB)) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .st_valid_i   (st_valid_i),
      .st_addr_i    (st_addr_i),
      .chk_tag_i    (chk_tag_i),
      .adv_tag_i    (adv_tag_i),
      .rearm_i      (rearm_vec[g]),
      .free_i       (free_vec[g]),
      .wr_i         (wr_vec[g]),
      .wr_addr_i    (adv_addr_i),
      .used_o       (used_vec[g]),
      .armed_o      (armed_vec[g]),
      .armed_post_o (armed_post[g]),
      .chk_match_o  (chk_match[g]),
      .adv_match_o  (adv_match[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q  <= 1'b0;
      recover_q <= 1'b0;
    end else begin
      reload_q  <= chk_valid_i & (kind == CHK_RELOAD) & aliased;
      recover_q <= chk_valid_i & (kind == CHK_BRANCH) & aliased;
    end
  end

  assign reload_o  = reload_q;
  assign recover_o = recover_q;
endmodule

// File: rtl/spec_ld_monitor_chk.sv
module spec_ld_monitor_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chk_valid_i,
  input logic             chk_branch_i,
  input logic             adv_valid_i,
  input logic             reload_o,
  input logic             recover_o,
  input logic [N-1:0]     used_vec,
  input logic [N-1:0]     armed_vec,
  input logic             table_full,
  input logic             adv_hit,
  input logic [IDX_W-1:0] victim_idx
);
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!reload_o && !recover_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(chk_valid_i) |-> (!reload_o && !recover_o));

  assert_armed_in_use_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_vec & ~used_vec) == '0);

  assert_reload_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> ($past(chk_valid_i) && !$past(chk_branch_i)));

  assert_recover_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> ($past(chk_valid_i) && $past(chk_branch_i)));

  assert_evict_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_valid_i && table_full && !adv_hit) |=> victim_idx != $past(victim_idx));
endmodule

bind spec_ld_monitor spec_ld_monitor_chk #(.N(ENTRIES), .IDX_W(IDX_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chk_valid_i  (chk_valid_i),
  .chk_branch_i (chk_branch_i),
  .adv_valid_i  (adv_valid_i),
  .reload_o     (reload_o),
  .recover_o    (recover_o),
  .used_vec     (used_vec),
  .armed_vec    (armed_vec),
  .table_full   (table_full),
  .adv_hit      (adv_hit),
  .victim_idx   (victim_idx)
);

// File: tb/test_spec_ld_monitor.sv
module test_spec_ld_monitor;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_v = 1'b0, st_v = 1'b0, ck_v = 1'b0, ck_br = 1'b0;
  logic [6:0]  adv_t = '0, ck_t = '0;
  logic [31:0] adv_a = '0, st_a = '0;
  logic        reload, recover;

  int  total = 0, bad = 0;
  bit  done = 0;

  // reference state
  bit          m_used[N];
  bit          m_armed[N];
  int          m_tag[N];
  int unsigned m_addr[N];
  int          m_rr;
  bit          e_reload, e_recover;

  always #10 clk = ~clk;

  spec_ld_monitor i_spec_ld_monitor (
    .clk_i(clk), .rst_ni(rst_n),
    .adv_valid_i(adv_v), .adv_tag_i(adv_t), .adv_addr_i(adv_a),
    .st_valid_i(st_v), .st_addr_i(st_a),
    .chk_valid_i(ck_v), .chk_branch_i(ck_br), .chk_tag_i(ck_t),
    .reload_o(reload), .recover_o(recover)
  );

  task automatic compare(input string req);
    total++;
    if (reload !== e_reload || recover !== e_recover) begin
      bad++;
      $display("FAIL %s: reload/recover actual=%b%b expected=%b%b at %0t",
               req, reload, recover, e_reload, e_recover, $time);
    end
  endtask

  task automatic model(input bit adv, input int at, input int unsigned aa,
                       input bit st, input int unsigned sa,
                       input bit ck, input bit br, input int ct);
    bit pre_used[N];
    int hit, j;
    bit alias_seen;
    // store first
    if (st)
      for (int i = 0; i < N; i++)
        if (m_used[i] && m_armed[i] && (m_addr[i] >> 3) == (sa >> 3)) m_armed[i] = 0;
    for (int i = 0; i < N; i++) pre_used[i] = m_used[i];
    // then check
    e_reload = 0; e_recover = 0;
    if (ck) begin
      hit = -1;
      for (int i = 0; i < N; i++) if (m_used[i] && m_tag[i] == ct) hit = i;
      alias_seen = (hit < 0) || !m_armed[hit];
      e_reload  = !br && alias_seen;
      e_recover = br && alias_seen;
      if (hit >= 0 && alias_seen) begin
        if (br) begin m_used[hit] = 0; m_armed[hit] = 0; end
        else m_armed[hit] = 1;
      end
    end
    // then hoisted load
    if (adv) begin
      j = -1;
      for (int i = 0; i < N; i++) if (pre_used[i] && m_tag[i] == at) j = i;
      if (j < 0) for (int i = N - 1; i >= 0; i--) if (!pre_used[i]) j = i;
      if (j < 0) begin j = m_rr; m_rr = (m_rr + 1) % N; end
      m_used[j] = 1; m_armed[j] = 1; m_tag[j] = at; m_addr[j] = aa;
    end
  endtask

  task automatic step(input bit adv, input int at, input int unsigned aa,
                      input bit st, input int unsigned sa,
                      input bit ck, input bit br, input int ct, input string req);
    adv_v = adv; adv_t = 7'(at); adv_a = aa;
    st_v = st; st_a = sa;
    ck_v = ck; ck_br = br; ck_t = 7'(ct);
    model(adv, at, aa, st, sa, ck, br, ct);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic chk(input bit br, input int ct, input string req);
    step(0, 0, 0, 0, 0, 1, br, ct, req);
  endtask

  task automatic adv(input int at, input int unsigned aa, input string req);
    step(1, at, aa, 0, 0, 0, 0, 0, req);
  endtask

  task automatic store(input int unsigned sa, input string req);
    step(0, 0, 0, 1, sa, 0, 0, 0, req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_used[i] = 0; m_armed[i] = 0; m_tag[i] = 0; m_addr[i] = 0; end
    m_rr = 0; e_reload = 0; e_recover = 0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    idle("R1 after reset");
    // empty table: check is aliased
    chk(0, 5, "R9 R1 empty table reload");
    chk(1, 6, "R9 empty table branch");
    // armed entry is a no-op
    adv(1, 32'h100, "R2 alloc");
    chk(0, 1, "R2 no alias no-op");
    idle("R2 idle quiet");
    // same granule store disarms
    store(32'h104, "R3 store in granule");
    chk(0, 1, "R3 R4 reload after alias");
    chk(0, 1, "R6 re-armed no-op");
    store(32'h108, "R3 store next granule");
    chk(0, 1, "R3 other granule no effect");
    // one store clears two entries
    adv(2, 32'h200, "R11 alloc a");
    adv(3, 32'h200, "R11 alloc b");
    store(32'h207, "R11 store");
    chk(1, 2, "R5 R11 branch recover");
    chk(0, 2, "R5 released entry aliased");
    chk(0, 3, "R11 second entry aliased");
    chk(0, 3, "R6 re-armed after reload");
    // overwrite existing tag
    adv(1, 32'h300, "R7 overwrite");
    store(32'h100, "R7 old address store");
    chk(0, 1, "R7 old address ignored");
    store(32'h300, "R7 new address store");
    chk(1, 1, "R7 R5 new address aliased");
    // fill and round-robin eviction
    for (int k = 0; k < 10; k++) adv(20 + k, 32'h1000 + 32'(k) * 16, "R8 fill");
    chk(0, 3, "R8 evicted tag aliased");
    chk(0, 20, "R8 evicted tag aliased");
    chk(0, 29, "R8 newest resident no-op");
    chk(0, 24, "R8 resident no-op");
    // same-cycle ordering: store, check, load
    step(1, 40, 32'h1040, 1, 32'h1040, 1, 0, 24, "R10 store before check");
    chk(0, 40, "R10 load after store stays armed");
    step(0, 0, 0, 1, 32'h1050, 1, 1, 25, "R10 branch sees store");
    step(1, 41, 32'h900, 0, 0, 1, 1, 41, "R10 check before load");
    chk(0, 41, "R10 new load armed");
    // mixed traffic
    for (int k = 0; k < 600; k++)
      step($urandom_range(0, 2) == 0, $urandom_range(0, 11), $urandom_range(0, 47),
           $urandom_range(0, 2) == 0, $urandom_range(0, 47),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom_range(0, 11),
           "R4 R5 R10 mixed");
    idle("R2 final idle");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule